// File: doc/BRIEF.md
# Endian-Configurable Load/Store Aligner

This block sits between a 32-bit core datapath and a byte-addressed memory port that is one word wide. Lane k of the memory word (bits 8k+7 down to 8k) always carries the byte whose address has low bits equal to k. On loads, the aligner takes the addressed byte, halfword or word out of the memory word and sign- or zero-extends it to 32 bits. On stores, it repeats the narrow write data across all lanes and raises only the byte enables of the addressed lanes.

A run-time mode input selects big-endian or little-endian interpretation. In little-endian mode, the lowest-addressed byte of an access is its least significant byte. In big-endian mode, it is the most significant byte. An access whose address is not a multiple of its size, or whose size code is reserved, raises a fault in the same cycle and is suppressed. A parameter can add one register stage on every output.

Top module: `lsu_aligner`

## Requirements
- R1: Memory lane k (bits 8k+7:8k) holds the byte at address offset k, so a byte load at offset k returns lane k in either endian mode.
- R2: With `big_endian_i` low, halfword and word loads take the byte at the lowest address as the least significant byte of the result.
- R3: With `big_endian_i` high, halfword and word loads take the byte at the lowest address as the most significant byte of the result.
- R4: Byte and halfword loads are zero-extended when `unsigned_i` is high and sign-extended when it is low. Word loads are not affected by `unsigned_i`.
- R5: On a store of n bytes (n = 1, 2 or 4), `mem_wdata_o` repeats the n-byte store pattern in every n-lane group. The addressed lanes carry the data in the selected byte order: little-endian puts the lowest-addressed byte from `wdata_i[7:0]`, big-endian puts it from the most significant byte of the n-byte value.
- R6: When `we_i` is high and the access is aligned, `mem_be_o` has ones exactly on lanes offset through offset+n-1. When `we_i` is low, `mem_be_o` is all zeros.
- R7: Size code 2'b00 means byte, 2'b01 halfword and 2'b10 word. 2'b11 is reserved. `misalign_fault_o` is high in the same cycle when the code is reserved, or when the offset `addr_i` is not a multiple of the access size.
- R8: While `misalign_fault_o` is high, `mem_be_o`, `rdata_o` and `mem_wdata_o` are all zero.
- R9: With `REG_OUT` set, every output follows the combinational result one clock later and is zero while `rst_ni` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used by the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| big_endian_i | input | 1 | 1 selects big-endian, 0 little-endian |
| we_i | input | 1 | 1 marks the access as a store |
| size_i | input | 2 | Access size code |
| unsigned_i | input | 1 | 1 zero-extends narrow loads |
| addr_i | input | OFF_W (2) | Byte offset of the access within the word |
| wdata_i | input | DATA_W (32) | Store data from the core, right-justified |
| mem_rdata_i | input | DATA_W (32) | Word read from memory |
| mem_wdata_o | output | DATA_W (32) | Lane-placed store data |
| mem_be_o | output | LANES (4) | Store byte enables, one per lane |
| rdata_o | output | DATA_W (32) | Aligned and extended load result |
| misalign_fault_o | output | 1 | Misaligned or reserved-size access |

## Verification
The assertions assume that all inputs change only away from the rising clock edge. With `REG_OUT` set, they also assume that one edge after reset release has passed before the registered outputs are compared against the previous combinational result. The bench drives every input on the falling edge and holds it through the next rising edge. It draws the size code from all four values and draws offsets freely, so faulting accesses occur as often as legal ones. It also releases reset on a falling edge, so the first registered comparison falls one full cycle later.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check #(
  parameter int unsigned LANES = 4,
  parameter int unsigned OFF_W = 2
) (
  input  logic [1:0]       size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             fault_o
);
  always_comb begin
    fault_o = 1'b0;
    if ((32'd1 << size_i) > LANES) begin
      fault_o = 1'b1;
    end else begin
      for (int b = 0; b < int'(OFF_W); b++) begin
        if (b < int'(size_i) && off_i[b]) fault_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 4,
  parameter int unsigned OFF_W  = 2
) (
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  input  logic              big_i,
  input  logic              uns_i,
  input  logic              fault_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] rev, shifted, ext;
  logic [31:0]       nb, sh;
  logic              sgn;

  // lane-reversed copy: lowest address moves to the top
  for (genvar k = 0; k < LANES; k++) begin : g_rev
    assign rev[8*k +: 8] = rdata_i[8*(LANES-1-k) +: 8];
  end

  always_comb begin
    nb = 32'd1 << size_i;
    if (nb > LANES) nb = LANES;
    sh = '0;
    if (int'(off_i) + nb <= LANES) begin
      sh = big_i ? 8 * (LANES - int'(off_i) - nb) : 8 * int'(off_i);
    end
    shifted = big_i ? (rev >> sh) : (rdata_i >> sh);
    sgn = shifted[8*nb-1] & ~uns_i;
    for (int k = 0; k < int'(LANES); k++) begin
      ext[8*k +: 8] = (k < int'(nb)) ? shifted[8*k +: 8] : {8{sgn}};
    end
    data_o = fault_i ? '0 : ext;
  end
endmodule

// File: rtl/lsu_store_place.sv
module lsu_store_place #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 4,
  parameter int unsigned OFF_W  = 2
) (
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  input  logic              big_i,
  input  logic              we_i,
  input  logic              fault_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [LANES-1:0]  be_o
);
  logic [DATA_W-1:0] chunk, rep;
  logic [31:0]       nb;

  always_comb begin
    nb = 32'd1 << size_i;
    if (nb > LANES) nb = LANES;
    // byte order inside one n-byte chunk
    for (int k = 0; k < int'(LANES); k++) begin
      if (big_i && k < int'(nb)) chunk[8*k +: 8] = wdata_i[8*(int'(nb)-1-k) +: 8];
      else                       chunk[8*k +: 8] = wdata_i[8*k +: 8];
    end
    for (int k = 0; k < int'(LANES); k++) begin
      rep[8*k +: 8] = chunk[8*(k % int'(nb)) +: 8];
      be_o[k] = we_i & ~fault_i & (k >= int'(off_i)) & (k < int'(off_i) + int'(nb));
    end
    wdata_o = fault_i ? '0 : rep;
  end
endmodule

// File: rtl/lsu_aligner.sv
module lsu_aligner
  import lsu_align_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter bit          REG_OUT = 1'b0,
  localparam int unsigned LANES  = DATA_W / 8,
  localparam int unsigned OFF_W  = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              big_endian_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic              unsigned_i,
  input  logic [OFF_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              misalign_fault_o
);
  logic              fault_c;
  logic [DATA_W-1:0] rdata_c, wdata_c;
  logic [LANES-1:0]  be_c;

  lsu_align_check #(.LANES(LANES), .OFF_W(OFF_W)) i_check (
    .size_i (size_i),
    .off_i  (addr_i),
    .fault_o(fault_c)
  );

  lsu_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) i_load (
    .rdata_i(mem_rdata_i),
    .off_i  (addr_i),
    .size_i (size_i),
    .big_i  (big_endian_i),
    .uns_i  (unsigned_i),
    .fault_i(fault_c),
    .data_o (rdata_c)
  );

  lsu_store_place #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) i_store (
    .wdata_i(wdata_i),
    .off_i  (addr_i),
    .size_i (size_i),
    .big_i  (big_endian_i),
    .we_i   (we_i),
    .fault_i(fault_c),
    .wdata_o(wdata_c),
    .be_o   (be_c)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_wdata_o      <= '0;
        mem_be_o         <= '0;
        rdata_o          <= '0;
        misalign_fault_o <= 1'b0;
      end else begin
        mem_wdata_o      <= wdata_c;
        mem_be_o         <= be_c;
        rdata_o          <= rdata_c;
        misalign_fault_o <= fault_c;
      end
    end

    // R9
    reg_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> (rdata_o == $past(rdata_c) && mem_be_o == $past(be_c)));
  end else begin : g_comb
    assign mem_wdata_o      = wdata_c;
    assign mem_be_o         = be_c;
    assign rdata_o          = rdata_c;
    assign misalign_fault_o = fault_c;
  end

  // R8
  fault_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_c |-> (be_c == '0 && rdata_c == '0 && wdata_c == '0));
  // R7
  rsvd_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == SZ_RSVD) |-> fault_c);
  // R6
  no_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |-> (be_c == '0));
  // R6
  byte_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && size_i == SZ_BYTE) |-> ($countones(be_c) == 1));
  // R6
  word_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && size_i == SZ_WORD && !fault_c) |-> (&be_c));
endmodule

// File: tb/test_lsu_aligner.sv
module test_lsu_aligner;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big, we, uns;
  logic [1:0]  size, addr;
  logic [31:0] wd, rd;
  logic [31:0] c_wd, c_rd, r_wd, r_rd;
  logic [3:0]  c_be, r_be;
  logic        c_ft, r_ft;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit have_prev = 1'b0;
  logic [31:0] p_rd, p_wd;
  logic [3:0]  p_be;
  logic        p_ft;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_aligner i_lsu_aligner (
    .clk_i(clk), .rst_ni(rst_n), .big_endian_i(big), .we_i(we), .size_i(size),
    .unsigned_i(uns), .addr_i(addr), .wdata_i(wd), .mem_rdata_i(rd),
    .mem_wdata_o(c_wd), .mem_be_o(c_be), .rdata_o(c_rd), .misalign_fault_o(c_ft)
  );

  lsu_aligner #(.REG_OUT(1'b1)) i_lsu_aligner_reg (
    .clk_i(clk), .rst_ni(rst_n), .big_endian_i(big), .we_i(we), .size_i(size),
    .unsigned_i(uns), .addr_i(addr), .wdata_i(wd), .mem_rdata_i(rd),
    .mem_wdata_o(r_wd), .mem_be_o(r_be), .rdata_o(r_rd), .misalign_fault_o(r_ft)
  );

  function automatic bit m_fault(logic [1:0] s, logic [1:0] a);
    if (s == 2'b11) return 1'b1;
    return (int'(a) % (1 << s)) != 0;
  endfunction

  function automatic logic [31:0] m_load(logic [31:0] r, logic [1:0] s, logic [1:0] a,
                                         logic b, logic u);
    int n;
    logic [31:0] v;
    if (m_fault(s, a)) return 32'h0;
    n = 1 << s;
    v = '0;
    for (int j = 0; j < n; j++) begin
      if (b) v = (v << 8) | 32'(r[8*(int'(a)+j) +: 8]);
      else   v = v | (32'(r[8*(int'(a)+j) +: 8]) << (8*j));
    end
    if (n < 4 && !u && v[8*n-1]) v = v | (32'hFFFF_FFFF << (8*n));
    return v;
  endfunction

  function automatic logic [31:0] m_wdata(logic [31:0] w, logic [1:0] s, logic [1:0] a,
                                          logic b);
    int n;
    logic [31:0] v;
    if (m_fault(s, a)) return 32'h0;
    n = 1 << s;
    v = '0;
    for (int k = 0; k < 4; k++) begin
      int j = k % n;
      v[8*k +: 8] = b ? w[8*(n-1-j) +: 8] : w[8*j +: 8];
    end
    return v;
  endfunction

  function automatic logic [3:0] m_be(logic [1:0] s, logic [1:0] a, logic e);
    logic [3:0] v;
    v = '0;
    if (!e || m_fault(s, a)) return v;
    for (int k = 0; k < (1 << s); k++) v[int'(a)+k] = 1'b1;
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive on falling edge; check registered copy of previous access first
  task automatic apply(logic b, logic e, logic [1:0] s, logic u, logic [1:0] a,
                       logic [31:0] w, logic [31:0] r);
    logic [31:0] erd;
    @(negedge clk);
    if (have_prev) begin
      chk("R9 rdata", r_rd, p_rd);
      chk("R9 wdata", r_wd, p_wd);
      chk("R9 be", 32'(r_be), 32'(p_be));
      chk("R9 fault", 32'(r_ft), 32'(p_ft));
    end
    big = b; we = e; size = s; uns = u; addr = a; wd = w; rd = r;
    #1;
    erd = m_load(r, s, a, b, u);
    chk("R7 fault", 32'(c_ft), 32'(m_fault(s, a)));
    chk(m_fault(s, a) ? "R8 rdata" : (s == 2'b00 ? "R1 R4 rdata" : (b ? "R3 R4 rdata" : "R2 R4 rdata")),
        c_rd, erd);
    chk(m_fault(s, a) ? "R8 wdata" : "R5 wdata", c_wd, m_wdata(w, s, a, b));
    chk(m_fault(s, a) ? "R8 be" : "R6 be", 32'(c_be), 32'(m_be(s, a, e)));
    p_rd = erd; p_wd = m_wdata(w, s, a, b); p_be = m_be(s, a, e); p_ft = m_fault(s, a);
    have_prev = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    big = 1'b1; we = 1'b1; size = 2'b10; uns = 1'b0; addr = 2'b00;
    wd = 32'hDEAD_BEEF; rd = 32'hCAFE_F00D;
    // R9: registered outputs held at zero in reset
    repeat (3) @(negedge clk);
    chk("R9 reset rdata", r_rd, 32'h0);
    chk("R9 reset wdata", r_wd, 32'h0);
    chk("R9 reset be", 32'(r_be), 32'h0);
    chk("R9 reset fault", 32'(r_ft), 32'h0);
    rst_n = 1'b1;

    // directed: hand-worked values on 0xA1B2C3D4 (lane0=D4)
    apply(1'b0, 1'b0, 2'b01, 1'b0, 2'd2, 32'h0, 32'hA1B2_C3D4);
    chk("R2 half le signed", c_rd, 32'hFFFF_A1B2);
    apply(1'b1, 1'b0, 2'b01, 1'b0, 2'd0, 32'h0, 32'hA1B2_C3D4);
    chk("R3 half be signed", c_rd, 32'hFFFF_D4C3);
    apply(1'b1, 1'b0, 2'b00, 1'b1, 2'd1, 32'h0, 32'hA1B2_C3D4);
    chk("R1 R4 byte unsigned", c_rd, 32'h0000_00C3);
    apply(1'b1, 1'b0, 2'b10, 1'b1, 2'd0, 32'h0, 32'hA1B2_C3D4);
    chk("R3 word be", c_rd, 32'hD4C3_B2A1);
    apply(1'b0, 1'b0, 2'b10, 1'b0, 2'd0, 32'h0, 32'hA1B2_C3D4);
    chk("R4 word ignores unsigned", c_rd, 32'hA1B2_C3D4);
    apply(1'b1, 1'b1, 2'b01, 1'b0, 2'd2, 32'h0000_1234, 32'h0);
    chk("R5 half be store", c_wd, 32'h1234_1234 ^ 32'h2626_2626);
    chk("R6 half be lanes", 32'(c_be), 32'h0000_000C);
    apply(1'b0, 1'b1, 2'b10, 1'b0, 2'd2, 32'h1111_2222, 32'h5555_5555);
    chk("R8 misaligned word", 32'(c_be), 32'h0);
    apply(1'b0, 1'b1, 2'b11, 1'b0, 2'd0, 32'h1111_2222, 32'h8080_8080);
    chk("R7 reserved size", 32'(c_ft), 32'h1);
    apply(1'b0, 1'b1, 2'b01, 1'b0, 2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R8 misaligned half", c_rd, 32'h0);

    seed = $urandom(32'd20240611);
    for (int i = 0; i < 3000; i++) begin
      apply(1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
            $urandom, $urandom);
    end
    @(negedge clk);
    chk("R9 last rdata", r_rd, p_rd);
    chk("R9 last be", 32'(r_be), 32'(p_be));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule